// File: doc/BRIEF.md
# Interrupt Source Controller with Rejection and Re-presentation

This block holds the state of a parameterised set of interrupt sources and turns their activity into present requests for one presentation controller. Each source is fixed at build time as a level source (it follows a wire) or a message source (it fires on a one-cycle pulse). Each source has a programmable target server and priority. The all-ones priority value masks the source. A present request carries the server, the global source number (the local index plus a base offset) and the priority. The request is held until the presentation side accepts it.

The presentation side can refuse a delivered source (reject), finish with one (EOI), or ask for another pass over everything outstanding (resend). Per-source status bits decide what is delivered again after each of these.

- Message sources latch a masked firing and deliver it when they are unmasked.
- Message sources remember a rejection until the next resend.
- Level sources track whether the line is up and whether a delivery is outstanding.

Two state machines drive the block.

- **Issue machine.** It has the states ISS_IDLE and ISS_OFFER.
  - ISS_IDLE goes to ISS_OFFER when an unmasked source has a delivery waiting. On that transition the lowest such index is loaded into the output registers.
  - ISS_OFFER goes back to ISS_IDLE when `pres_ready` is high.
- **Scan machine.** It has the states SCN_IDLE and SCN_WALK.
  - SCN_IDLE goes to SCN_WALK when `resend_req` is seen.
  - SCN_WALK visits one source per cycle in ascending order. It holds its index while an offer waits for acceptance, and returns to SCN_IDLE after the last source.

Top module: `irq_source_ctl`

## Requirements
- R1: After reset `pres_valid` is low and every source is masked (priority all ones). A message fired before any configuration write presents nothing.
- R2: A message source with priority other than all ones presents when fired. The request carries its configured server, its priority, and number BASE_NUM plus its index.
- R3: A message fired while masked presents nothing and is latched. The next configuration write that gives it an unmasked priority presents it once. A further unmasking write presents nothing. No request ever carries the masked priority.
- R4: A level source that is unmasked presents once when its line rises and becomes outstanding. While it stays outstanding, a resend presents nothing, even with the line still high.
- R5: A reject whose number matches a message source marks it. The next resend presents it again. A resend with no reject since the last one presents nothing.
- R6: A reject of an outstanding level source clears the outstanding mark. A following resend presents it again while its line is high.
- R7: An EOI of a level source clears the outstanding mark, so a resend presents it again while its line is high. An EOI of a message source has no effect, and a resend after it presents nothing.
- R8: Reject and EOI numbers below BASE_NUM, or at or above BASE_NUM+NUM_SRC, change no source.
- R9: A resend visits sources in ascending index order, so outstanding deliveries appear lowest index first. A request is held with unchanged fields until `pres_ready`, and only one is accepted per cycle.
- R10: A level source with its line high while masked presents nothing. A configuration write that unmasks it presents it.
- R11: A level source whose line has fallen is not presented by a resend after a reject.
- R12: Reset keeps each source's kind. A level source whose line is high after reset presents on the unmasking configuration write, with no message pulse needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_line | input | NUM_SRC | Level of each level source's wire (ignored for message sources) |
| msg_valid | input | 1 | One-cycle message pulse |
| msg_idx | input | IDX_W | Local index of the message source that fires |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Local index being configured |
| cfg_server | input | SRV_W | New target server |
| cfg_prio | input | PRIO_W | New priority (all ones masks) |
| rej_valid | input | 1 | Reject strobe from the presentation side |
| rej_num | input | NUM_W | Global number being rejected |
| eoi_valid | input | 1 | EOI strobe |
| eoi_num | input | NUM_W | Global number being completed |
| resend_req | input | 1 | Request for a resend scan |
| pres_valid | output | 1 | Present request is held |
| pres_ready | input | 1 | Presentation side accepts the held request |
| pres_server | output | SRV_W | Target server of the request |
| pres_num | output | NUM_W | Global source number of the request |
| pres_prio | output | PRIO_W | Priority of the request |

## Verification
Status bits are never visible directly, so a wrong bit shows up as a present request that is missing, extra or repeated. For an extra or missing request from an event, this is seen two clock edges after the event. For one caused by a resend, it is seen within NUM_SRC+2 cycles, once the scan reaches the source. The checks therefore pair every reject, EOI or line change with a resend, and watch a window long enough for a full scan. A wrong issue order or a dropped hold shows at once as a changed number while `pres_ready` is low.

// File: rtl/irq_src_pkg.sv
package irq_src_pkg;

    typedef struct packed {
        logic asserted;   // level source: line seen high
        logic sent;       // level source: delivery outstanding
        logic rejected;   // message source: refused, waits for resend
        logic mpend;      // message source: fired while masked
    } src_stat_t;

    typedef enum logic [0:0] {
        ISS_IDLE  = 1'b0,
        ISS_OFFER = 1'b1
    } iss_state_t;

    typedef enum logic [0:0] {
        SCN_IDLE = 1'b0,
        SCN_WALK = 1'b1
    } scn_state_t;

endpackage

// File: rtl/irq_src_slot.sv
module irq_src_slot
    import irq_src_pkg::*;
#(
    parameter bit IS_LSI = 1'b0,
    parameter int SRV_W  = 4,
    parameter int PRIO_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line,
    input  logic              msi_fire,
    input  logic              cfg_hit,
    input  logic [SRV_W-1:0]  cfg_server,
    input  logic [PRIO_W-1:0] cfg_prio,
    input  logic              rej_hit,
    input  logic              eoi_hit,
    input  logic              scan_hit,
    input  logic              grant,
    output logic              pend,
    output logic              unmasked,
    output logic [SRV_W-1:0]  server,
    output logic [PRIO_W-1:0] prio,
    output src_stat_t         stat
);

    localparam logic [PRIO_W-1:0] PRIO_OFF = '1;

    src_stat_t         st_q, st_n;
    logic              pend_q, pend_n;
    logic [SRV_W-1:0]  srv_q, srv_n;
    logic [PRIO_W-1:0] prio_q, prio_n;
    logic              unm_n;

    always_comb begin
        srv_n  = srv_q;
        prio_n = prio_q;
        if (cfg_hit) begin
            srv_n  = cfg_server;
            prio_n = cfg_prio;
        end
        unm_n  = (prio_n != PRIO_OFF);
        st_n   = st_q;
        pend_n = pend_q & ~grant;

        if (IS_LSI) begin
            st_n.rejected = 1'b0;
            st_n.mpend    = 1'b0;
            st_n.asserted = line;
            if (rej_hit || eoi_hit) begin
                st_n.sent = 1'b0;
            end
            if ((line != st_q.asserted || cfg_hit || scan_hit)
                && unm_n && line && !st_n.sent) begin
                st_n.sent = 1'b1;
                pend_n    = 1'b1;
            end
        end else begin
            st_n.asserted = 1'b0;
            st_n.sent     = 1'b0;
            if (rej_hit) begin
                st_n.rejected = 1'b1;
            end
            if (msi_fire) begin
                if (unm_n) begin
                    pend_n = 1'b1;
                end else begin
                    st_n.mpend = 1'b1;
                end
            end
            if (cfg_hit && st_n.mpend && unm_n) begin
                st_n.mpend = 1'b0;
                pend_n     = 1'b1;
            end
            if (scan_hit && st_q.rejected) begin
                st_n.rejected = 1'b0;
                if (unm_n) begin
                    pend_n = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= '0;
            pend_q <= 1'b0;
            srv_q  <= '0;
            prio_q <= PRIO_OFF;
        end else begin
            st_q   <= st_n;
            pend_q <= pend_n;
            srv_q  <= srv_n;
            prio_q <= prio_n;
        end
    end

    assign pend     = pend_q;
    assign unmasked = (prio_q != PRIO_OFF);
    assign server   = srv_q;
    assign prio     = prio_q;
    assign stat     = st_q;

endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter int NUM_SRC = 8,
    parameter int IDX_W   = 3
) (
    input  logic [NUM_SRC-1:0] req,
    output logic [NUM_SRC-1:0] gnt,
    output logic [IDX_W-1:0]   idx,
    output logic               any
);

    always_comb begin
        gnt = '0;
        idx = '0;
        any = |req;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt    = '0;
                gnt[i] = 1'b1;
                idx    = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_issue_fsm.sv
module irq_issue_fsm
    import irq_src_pkg::*;
#(
    parameter int              SRV_W    = 4,
    parameter int              PRIO_W   = 8,
    parameter int              NUM_W    = 12,
    parameter int              IDX_W    = 3,
    parameter logic [NUM_W-1:0] BASE_NUM = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cand_any,
    input  logic [IDX_W-1:0]  cand_idx,
    input  logic [SRV_W-1:0]  cand_server,
    input  logic [PRIO_W-1:0] cand_prio,
    input  logic              pres_ready,
    output logic              grant_en,
    output logic              pres_valid,
    output logic [SRV_W-1:0]  pres_server,
    output logic [NUM_W-1:0]  pres_num,
    output logic [PRIO_W-1:0] pres_prio
);

    iss_state_t state_q, state_n;

    always_comb begin
        state_n  = state_q;
        grant_en = 1'b0;
        unique case (state_q)
            ISS_IDLE: begin
                if (cand_any) begin
                    grant_en = 1'b1;
                    state_n  = ISS_OFFER;
                end
            end
            ISS_OFFER: begin
                if (pres_ready) begin
                    state_n = ISS_IDLE;
                end
            end
            default: state_n = ISS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ISS_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pres_server <= '0;
            pres_num    <= '0;
            pres_prio   <= '0;
        end else if (grant_en) begin
            pres_server <= cand_server;
            pres_num    <= BASE_NUM + NUM_W'(cand_idx);
            pres_prio   <= cand_prio;
        end
    end

    assign pres_valid = (state_q == ISS_OFFER);

endmodule

// File: rtl/irq_scan_fsm.sv
module irq_scan_fsm
    import irq_src_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int IDX_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               resend_req,
    input  logic               busy,
    output logic [NUM_SRC-1:0] scan_hit
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_SRC - 1);

    scn_state_t       state_q, state_n;
    logic [IDX_W-1:0] idx_q, idx_n;

    always_comb begin
        state_n  = state_q;
        idx_n    = idx_q;
        scan_hit = '0;
        unique case (state_q)
            SCN_IDLE: begin
                if (resend_req) begin
                    idx_n   = '0;
                    state_n = SCN_WALK;
                end
            end
            SCN_WALK: begin
                if (!busy) begin
                    for (int i = 0; i < NUM_SRC; i++) begin
                        scan_hit[i] = (idx_q == IDX_W'(i));
                    end
                    if (idx_q == LAST) begin
                        state_n = SCN_IDLE;
                    end else begin
                        idx_n = idx_q + 1'b1;
                    end
                end
            end
            default: state_n = SCN_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SCN_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_n;
            idx_q   <= idx_n;
        end
    end

endmodule

// File: rtl/irq_source_ctl.sv
module irq_source_ctl
    import irq_src_pkg::*;
#(
    parameter int                NUM_SRC  = 8,
    parameter logic [NUM_SRC-1:0] LSI_MASK = 8'hF0,
    parameter int                SRV_W    = 4,
    parameter int                PRIO_W   = 8,
    parameter int                NUM_W    = 12,
    parameter logic [NUM_W-1:0]  BASE_NUM = 12'h100,
    localparam int               IDX_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_line,
    input  logic               msg_valid,
    input  logic [IDX_W-1:0]   msg_idx,
    input  logic               cfg_we,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic [SRV_W-1:0]   cfg_server,
    input  logic [PRIO_W-1:0]  cfg_prio,
    input  logic               rej_valid,
    input  logic [NUM_W-1:0]   rej_num,
    input  logic               eoi_valid,
    input  logic [NUM_W-1:0]   eoi_num,
    input  logic               resend_req,
    output logic               pres_valid,
    input  logic               pres_ready,
    output logic [SRV_W-1:0]   pres_server,
    output logic [NUM_W-1:0]   pres_num,
    output logic [PRIO_W-1:0]  pres_prio
);

    logic [NUM_SRC-1:0] pend_vec, unm_vec, cand_vec, gnt_vec, slot_grant;
    logic [NUM_SRC-1:0] scan_hit, sent_vec, mpend_vec;
    logic [SRV_W-1:0]   srv_arr  [NUM_SRC];
    logic [PRIO_W-1:0]  prio_arr [NUM_SRC];
    src_stat_t          stat_arr [NUM_SRC];
    logic [IDX_W-1:0]   cand_idx;
    logic               cand_any, grant_en;
    logic [SRV_W-1:0]   cand_server;
    logic [PRIO_W-1:0]  cand_prio;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_slot
        localparam logic [NUM_W-1:0] SNUM = BASE_NUM + NUM_W'(g);
        logic msi_fire, cfg_hit, rej_hit, eoi_hit;

        assign msi_fire = msg_valid && (msg_idx == IDX_W'(g));
        assign cfg_hit  = cfg_we && (cfg_idx == IDX_W'(g));
        assign rej_hit  = rej_valid && (rej_num == SNUM);
        assign eoi_hit  = eoi_valid && (eoi_num == SNUM);

        irq_src_slot #(
            .IS_LSI (LSI_MASK[g]),
            .SRV_W  (SRV_W),
            .PRIO_W (PRIO_W)
        ) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .line       (src_line[g]),
            .msi_fire   (msi_fire),
            .cfg_hit    (cfg_hit),
            .cfg_server (cfg_server),
            .cfg_prio   (cfg_prio),
            .rej_hit    (rej_hit),
            .eoi_hit    (eoi_hit),
            .scan_hit   (scan_hit[g]),
            .grant      (slot_grant[g]),
            .pend       (pend_vec[g]),
            .unmasked   (unm_vec[g]),
            .server     (srv_arr[g]),
            .prio       (prio_arr[g]),
            .stat       (stat_arr[g])
        );

        assign sent_vec[g]  = stat_arr[g].sent;
        assign mpend_vec[g] = stat_arr[g].mpend;
    end

    assign cand_vec   = pend_vec & unm_vec;
    assign slot_grant = gnt_vec & {NUM_SRC{grant_en}};

    irq_pick #(
        .NUM_SRC (NUM_SRC),
        .IDX_W   (IDX_W)
    ) u_pick (
        .req (cand_vec),
        .gnt (gnt_vec),
        .idx (cand_idx),
        .any (cand_any)
    );

    always_comb begin
        cand_server = '0;
        cand_prio   = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (gnt_vec[i]) begin
                cand_server = srv_arr[i];
                cand_prio   = prio_arr[i];
            end
        end
    end

    irq_issue_fsm #(
        .SRV_W    (SRV_W),
        .PRIO_W   (PRIO_W),
        .NUM_W    (NUM_W),
        .IDX_W    (IDX_W),
        .BASE_NUM (BASE_NUM)
    ) u_issue (
        .clk         (clk),
        .rst_n       (rst_n),
        .cand_any    (cand_any),
        .cand_idx    (cand_idx),
        .cand_server (cand_server),
        .cand_prio   (cand_prio),
        .pres_ready  (pres_ready),
        .grant_en    (grant_en),
        .pres_valid  (pres_valid),
        .pres_server (pres_server),
        .pres_num    (pres_num),
        .pres_prio   (pres_prio)
    );

    irq_scan_fsm #(
        .NUM_SRC (NUM_SRC),
        .IDX_W   (IDX_W)
    ) u_scan (
        .clk        (clk),
        .rst_n      (rst_n),
        .resend_req (resend_req),
        .busy       (pres_valid && !pres_ready),
        .scan_hit   (scan_hit)
    );

endmodule

// File: rtl/irq_src_chk.sv
module irq_src_chk #(
    parameter int                NUM_SRC  = 8,
    parameter logic [NUM_SRC-1:0] LSI_MASK = 8'hF0,
    parameter int                SRV_W    = 4,
    parameter int                PRIO_W   = 8,
    parameter int                NUM_W    = 12,
    parameter logic [NUM_W-1:0]  BASE_NUM = 12'h100
) (
    input logic               clk,
    input logic               rst_n,
    input logic               pres_valid,
    input logic               pres_ready,
    input logic [SRV_W-1:0]   pres_server,
    input logic [NUM_W-1:0]   pres_num,
    input logic [PRIO_W-1:0]  pres_prio,
    input logic [NUM_SRC-1:0] sent_vec,
    input logic [NUM_SRC-1:0] mpend_vec
);

    localparam int LO = int'(BASE_NUM);
    localparam int HI = LO + NUM_SRC;

    AST_OFFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        pres_valid && !pres_ready |=> pres_valid && $stable(pres_num)
            && $stable(pres_prio) && $stable(pres_server)); // R9

    AST_ONE_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        pres_valid && pres_ready |=> !pres_valid); // R9

    AST_NUM_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        pres_valid |-> (int'(pres_num) >= LO) && (int'(pres_num) < HI)); // R2

    AST_NO_MASKED_PRES: assert property (@(posedge clk) disable iff (!rst_n)
        pres_valid |-> pres_prio != '1); // R3

    AST_SENT_LEVEL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (sent_vec & ~LSI_MASK) == '0); // R4

    AST_LATCH_MSG_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (mpend_vec & LSI_MASK) == '0); // R3

endmodule

bind irq_source_ctl irq_src_chk #(
    .NUM_SRC  (NUM_SRC),
    .LSI_MASK (LSI_MASK),
    .SRV_W    (SRV_W),
    .PRIO_W   (PRIO_W),
    .NUM_W    (NUM_W),
    .BASE_NUM (BASE_NUM)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pres_valid  (pres_valid),
    .pres_ready  (pres_ready),
    .pres_server (pres_server),
    .pres_num    (pres_num),
    .pres_prio   (pres_prio),
    .sent_vec    (sent_vec),
    .mpend_vec   (mpend_vec)
);

// File: tb/irq_source_ctl_bench.sv
`timescale 1ns/1ps
module irq_source_ctl_bench;

    localparam int         N     = 8;
    localparam logic [11:0] BASE = 12'h100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N-1:0] src_line = '0;
    logic        msg_valid = 1'b0;
    logic [2:0]  msg_idx = '0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [3:0]  cfg_server = '0;
    logic [7:0]  cfg_prio = '0;
    logic        rej_valid = 1'b0;
    logic [11:0] rej_num = '0;
    logic        eoi_valid = 1'b0;
    logic [11:0] eoi_num = '0;
    logic        resend_req = 1'b0;
    logic        pres_valid;
    logic        pres_ready = 1'b0;
    logic [3:0]  pres_server;
    logic [11:0] pres_num;
    logic [7:0]  pres_prio;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    irq_source_ctl u_irq_source_ctl (
        .clk(clk), .rst_n(rst_n), .src_line(src_line),
        .msg_valid(msg_valid), .msg_idx(msg_idx),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_server(cfg_server), .cfg_prio(cfg_prio),
        .rej_valid(rej_valid), .rej_num(rej_num),
        .eoi_valid(eoi_valid), .eoi_num(eoi_num),
        .resend_req(resend_req),
        .pres_valid(pres_valid), .pres_ready(pres_ready),
        .pres_server(pres_server), .pres_num(pres_num), .pres_prio(pres_prio)
    );

    // {index[3:0], server[3:0], priority[7:0]} for message sources
    localparam logic [15:0] VEC [4] = '{16'h1_1_03, 16'h2_7_00, 16'h3_F_FE, 16'h0_9_10};

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cfg(input int idx, input int srv, input int prio);
        cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_server = 4'(srv); cfg_prio = 8'(prio);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic fire(input int idx);
        msg_valid = 1'b1; msg_idx = 3'(idx);
        @(negedge clk);
        msg_valid = 1'b0;
    endtask

    task automatic reject(input int num);
        rej_valid = 1'b1; rej_num = 12'(num);
        @(negedge clk);
        rej_valid = 1'b0;
    endtask

    task automatic eoi(input int num);
        eoi_valid = 1'b1; eoi_num = 12'(num);
        @(negedge clk);
        eoi_valid = 1'b0;
    endtask

    task automatic resend();
        resend_req = 1'b1;
        @(negedge clk);
        resend_req = 1'b0;
    endtask

    task automatic expect_pres(input int num, input int srv, input int prio, input string req);
        for (int k = 0; k < 12 && !pres_valid; k++) @(negedge clk);
        chk(pres_valid, req, "pres_valid", int'(pres_valid), 1);
        if (pres_valid) begin
            chk(pres_num == 12'(num) && pres_server == 4'(srv) && pres_prio == 8'(prio),
                req, "num/server/prio",
                {pres_num, pres_server, pres_prio}, {12'(num), 4'(srv), 8'(prio)});
            pres_ready = 1'b1;
            @(negedge clk);
            pres_ready = 1'b0;
        end
    endtask

    task automatic expect_quiet(input int n, input string req);
        bit seen = 1'b0;
        int got = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (pres_valid && !seen) begin
                seen = 1'b1;
                got  = int'(pres_num);
            end
        end
        chk(!seen, req, "unexpected present num", got, 0);
        if (pres_valid) begin
            pres_ready = 1'b1;
            @(negedge clk);
            pres_ready = 1'b0;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!pres_valid, "R1", "pres_valid after reset", int'(pres_valid), 0);

        // R1 / R3: masked message is latched, then released by unmask
        fire(0);
        expect_quiet(6, "R1");
        cfg(0, 3, 5);
        expect_pres(BASE + 0, 3, 5, "R3");
        cfg(0, 3, 5);
        expect_quiet(6, "R3");

        // R2: table of message sources
        foreach (VEC[i]) begin
            cfg(int'(VEC[i][15:12]), int'(VEC[i][11:8]), int'(VEC[i][7:0]));
            fire(int'(VEC[i][15:12]));
            expect_pres(BASE + int'(VEC[i][15:12]), int'(VEC[i][11:8]),
                        int'(VEC[i][7:0]), "R2");
        end

        // R5: reject and resend of a message source
        reject(BASE + 1);
        resend();
        expect_pres(BASE + 1, 1, 8'h03, "R5");
        resend();
        expect_quiet(16, "R5");

        // R8: out-of-range rejects
        reject(BASE + N);
        reject(BASE - 1);
        resend();
        expect_quiet(16, "R8");

        // R4: level source
        cfg(4, 2, 4);
        src_line[4] = 1'b1;
        expect_pres(BASE + 4, 2, 4, "R4");
        resend();
        expect_quiet(16, "R4");

        eoi(BASE + N);
        resend();
        expect_quiet(16, "R8");

        // R7: EOI on level source
        eoi(BASE + 4);
        resend();
        expect_pres(BASE + 4, 2, 4, "R7");

        // R6: reject on level source
        reject(BASE + 4);
        resend();
        expect_pres(BASE + 4, 2, 4, "R6");

        // R11: line fallen
        src_line[4] = 1'b0;
        @(negedge clk);
        reject(BASE + 4);
        resend();
        expect_quiet(16, "R11");

        // R7: EOI on a message source has no effect
        eoi(BASE + 2);
        resend();
        expect_quiet(16, "R7");

        // R10: masked level source, then unmask
        src_line[5] = 1'b1;
        expect_quiet(6, "R10");
        cfg(5, 6, 6);
        expect_pres(BASE + 5, 6, 6, "R10");

        // R9: ordering and hold
        reject(BASE + 3);
        reject(BASE + 5);
        reject(BASE + 1);
        reject(BASE + 2);
        resend();
        for (int k = 0; k < 12 && !pres_valid; k++) @(negedge clk);
        chk(pres_valid && pres_num == 12'(BASE + 1), "R9", "first in order",
            int'(pres_num), BASE + 1);
        repeat (3) @(negedge clk);
        chk(pres_valid && pres_num == 12'(BASE + 1) && pres_prio == 8'h03, "R9",
            "held while not ready", int'(pres_num), BASE + 1);
        pres_ready = 1'b1;
        @(negedge clk);
        pres_ready = 1'b0;
        expect_pres(BASE + 2, 7, 8'h00, "R9");
        expect_pres(BASE + 3, 15, 8'hFE, "R9");
        expect_pres(BASE + 5, 6, 6, "R9");
        expect_quiet(16, "R9");

        // R12: reset keeps kind; level source presents on unmask
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!pres_valid, "R1", "pres_valid after second reset", int'(pres_valid), 0);
        cfg(5, 1, 2);
        expect_pres(BASE + 5, 1, 2, "R12");
        cfg(1, 4, 7);
        expect_quiet(6, "R12");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule